// File: doc/BRIEF.md
# Incremental Nibble Log Appender

This controller turns a single flash word into a small append-only log of 4-bit entries. After an erase the word holds all ones. Each append programs one word in which only the next free nibble carries the new value and every other bit is written as 1. Flash ignores a programmed 1, so the entries already in the word stay intact, and one word can take eight appends before it needs another erase. This suits data-logging use, where flash lifetime matters.

The block keeps a count of the entries written since the last erase. It drives a program request toward a flash port and holds that request until the port acknowledges it. When the word is full, an append request is turned into an erase request, and the count clears when the flash reports that the erase is complete. The block also extracts the newest entry from a word that has been read back from flash.

Top module: `nibble_log_appender`

## Requirements
- R1: After reset the entry count is 0, `full` is 0, `ready` is 1, neither `prog_req` nor `erase_req` is asserted, and `latest_valid` is 0.
- R2: An append accepted while the count n is below 8 asserts `prog_req` on the next cycle. `prog_word` then carries the 4-bit value in bits [4n+3:4n], and every other bit is 1.
- R3: While `prog_ack` is low, `prog_req` stays asserted and `prog_word` does not change.
- R4: `prog_ack` during a pending program ends the request, raises the count by one and returns `ready` to 1 on the next cycle. The count never exceeds 8.
- R5: `full` is 1 exactly when the count is 8. An append request while `full` is 1 issues no program. It asserts `erase_req` on the next cycle instead.
- R6: `erase_req` stays asserted until `erase_done`. After `erase_done` the count is 0 and `full` is 0 on the next cycle.
- R7: When the count c is nonzero, `latest` equals bits [4(c-1)+3:4(c-1)] of `rd_word` and `latest_valid` is 1. When the count is 0, `latest_valid` is 0 and `latest` is 0.
- R8: `app_req` while `ready` is 0 is ignored. `prog_ack` outside a pending program and `erase_done` outside a pending erase have no effect on the count, the requests or `ready`.
- R9: `prog_req` and `erase_req` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| app_req | input | 1 | Append request, sampled while ready |
| app_data | input | 4 | Value to append |
| ready | output | 1 | Controller idle and able to take a request |
| prog_req | output | 1 | Program request to flash, held until acknowledged |
| prog_word | output | 32 | Word to program: new nibble in its slot, ones elsewhere |
| prog_ack | input | 1 | Flash program complete |
| erase_req | output | 1 | Erase request to flash, held until done |
| erase_done | input | 1 | Flash erase complete |
| full | output | 1 | All eight slots used since the last erase |
| entries | output | 4 | Entries written since the last erase (0..8) |
| rd_word | input | 32 | Word read back from flash |
| latest | output | 4 | Newest entry decoded from rd_word |
| latest_valid | output | 1 | latest holds a real entry |

## Verification
The bench fills the word with all eight slots and steps past the end. A slot index that is off by one, or a counter that wraps, would program over an existing nibble or skip the erase on the ninth request. It sends acknowledge and erase-complete pulses while no request is pending, and append requests while the controller is busy. A design that accepted any of these would change the count or start a second request. It also varies the acknowledge latency, so a request that drops or changes its word before the acknowledge shows up at once. The newest entry is read back from a modelled flash word and compared with a log of the appended values. The values include 0x0 and 0xF, which expose a decoder that is off by one nibble or that fails to force the output to 0 after an erase.

// File: rtl/nla_pkg.sv
package nla_pkg;
  typedef enum logic [1:0] {
    NLA_IDLE  = 2'd0,
    NLA_PROG  = 2'd1,
    NLA_ERASE = 2'd2
  } nla_state_e;
endpackage

// File: rtl/nla_word_builder.sv
module nla_word_builder #(
  parameter int NIB_W = 4,
  parameter int SLOTS = 8,
  localparam int WORD_W = NIB_W * SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [CNT_W-1:0]  slot,
  input  logic [NIB_W-1:0]  data,
  output logic [WORD_W-1:0] word
);
  // Each slot gets the data when selected, all ones otherwise
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign word[g*NIB_W +: NIB_W] = (slot == CNT_W'(g)) ? data : {NIB_W{1'b1}};
  end
endmodule

// File: rtl/nla_entry_counter.sv
module nla_entry_counter #(
  parameter int SLOTS = 8,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c, logic i, logic k);
    if (k)                               return '0;
    else if (i && c < CNT_W'(SLOTS))     return c + CNT_W'(1);
    else                                 return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, inc, clr);
  end

  assign full = (count == CNT_W'(SLOTS));
endmodule

// File: rtl/nla_sequencer.sv
module nla_sequencer
  import nla_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       app_req,
  input  logic       full,
  input  logic       prog_ack,
  input  logic       erase_done,
  output nla_state_e state,
  output logic       ev_append,
  output logic       ev_overflow,
  output logic       ev_prog_done,
  output logic       ev_erase_done
);
  nla_state_e state_nx;

  assign ev_append     = (state == NLA_IDLE)  && app_req && !full;
  assign ev_overflow   = (state == NLA_IDLE)  && app_req &&  full;
  assign ev_prog_done  = (state == NLA_PROG)  && prog_ack;
  assign ev_erase_done = (state == NLA_ERASE) && erase_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      NLA_IDLE: begin
        if (ev_append)        state_nx = NLA_PROG;
        else if (ev_overflow) state_nx = NLA_ERASE;
      end
      NLA_PROG:  if (ev_prog_done)  state_nx = NLA_IDLE;
      NLA_ERASE: if (ev_erase_done) state_nx = NLA_IDLE;
      default:   state_nx = NLA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= NLA_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/nla_latest_decode.sv
module nla_latest_decode #(
  parameter int NIB_W = 4,
  parameter int SLOTS = 8,
  localparam int WORD_W = NIB_W * SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [WORD_W-1:0] rd_word,
  input  logic [CNT_W-1:0]  count,
  output logic [NIB_W-1:0]  latest,
  output logic              latest_valid
);
  // Newest entry sits in the slot just below the count
  function automatic logic [NIB_W-1:0] pick_newest(logic [WORD_W-1:0] w, logic [CNT_W-1:0] c);
    logic [NIB_W-1:0] r;
    r = '0;
    for (int g = 0; g < SLOTS; g++) begin
      if (c == CNT_W'(g + 1)) r = w[g*NIB_W +: NIB_W];
    end
    return r;
  endfunction

  assign latest       = pick_newest(rd_word, count);
  assign latest_valid = (count != '0);
endmodule

// File: rtl/nibble_log_appender.sv
module nibble_log_appender
  import nla_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SLOTS = 8,
  localparam int WORD_W = NIB_W * SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_req,
  input  logic [NIB_W-1:0]  app_data,
  output logic              ready,
  output logic              prog_req,
  output logic [WORD_W-1:0] prog_word,
  input  logic              prog_ack,
  output logic              erase_req,
  input  logic              erase_done,
  output logic              full,
  output logic [CNT_W-1:0]  entries,
  input  logic [WORD_W-1:0] rd_word,
  output logic [NIB_W-1:0]  latest,
  output logic              latest_valid
);
  nla_state_e        state;
  logic              ev_append, ev_overflow, ev_prog_done, ev_erase_done;
  logic [WORD_W-1:0] built_word;

  nla_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .app_req       (app_req),
    .full          (full),
    .prog_ack      (prog_ack),
    .erase_done    (erase_done),
    .state         (state),
    .ev_append     (ev_append),
    .ev_overflow   (ev_overflow),
    .ev_prog_done  (ev_prog_done),
    .ev_erase_done (ev_erase_done)
  );

  nla_entry_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_prog_done),
    .clr   (ev_erase_done),
    .count (entries),
    .full  (full)
  );

  nla_word_builder #(.NIB_W(NIB_W), .SLOTS(SLOTS)) u_build (
    .slot (entries),
    .data (app_data),
    .word (built_word)
  );

  nla_latest_decode #(.NIB_W(NIB_W), .SLOTS(SLOTS)) u_dec (
    .rd_word      (rd_word),
    .count        (entries),
    .latest       (latest),
    .latest_valid (latest_valid)
  );

  // Capture the program word when an append is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prog_word <= '1;
    else if (ev_append) prog_word <= built_word;
  end

  assign ready     = (state == NLA_IDLE);
  assign prog_req  = (state == NLA_PROG);
  assign erase_req = (state == NLA_ERASE);
endmodule

// File: rtl/nla_checker.sv
module nla_checker #(
  parameter int NIB_W = 4,
  parameter int SLOTS = 8,
  localparam int WORD_W = NIB_W * SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              app_req,
  input logic              ready,
  input logic              prog_req,
  input logic [WORD_W-1:0] prog_word,
  input logic              prog_ack,
  input logic              erase_req,
  input logic              erase_done,
  input logic              full,
  input logic [CNT_W-1:0]  entries,
  input logic [NIB_W-1:0]  latest,
  input logic              latest_valid,
  input logic              ev_overflow,
  input logic              ev_prog_done,
  input logic              ev_erase_done
);
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));

  a_r2_ones_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($countones(prog_word) >= WORD_W - NIB_W));

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !prog_ack) |=> (prog_req && $stable(prog_word)));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog_done |=> (entries == $past(entries) + CNT_W'(1)));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    entries <= CNT_W'(SLOTS));

  a_r5_overflow_erases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (erase_req && !prog_req));

  a_r6_erase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_done) |=> erase_req);

  a_r6_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase_done |=> (entries == '0 && !full));

  a_r7_empty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (entries == '0) |-> (!latest_valid && latest == '0));

  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && app_req && !prog_ack && !erase_done) |=> $stable(entries));
endmodule

bind nibble_log_appender nla_checker #(.NIB_W(NIB_W), .SLOTS(SLOTS)) u_nla_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .app_req       (app_req),
  .ready         (ready),
  .prog_req      (prog_req),
  .prog_word     (prog_word),
  .prog_ack      (prog_ack),
  .erase_req     (erase_req),
  .erase_done    (erase_done),
  .full          (full),
  .entries       (entries),
  .latest        (latest),
  .latest_valid  (latest_valid),
  .ev_overflow   (ev_overflow),
  .ev_prog_done  (ev_prog_done),
  .ev_erase_done (ev_erase_done)
);

// File: tb/test_nibble_log_appender.sv
module test_nibble_log_appender;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        app_req = 1'b0;
  logic [3:0]  app_data = 4'h0;
  logic        ready, prog_req, erase_req, full, latest_valid;
  logic [31:0] prog_word;
  logic        prog_ack = 1'b0;
  logic        erase_done = 1'b0;
  logic [3:0]  entries, latest;
  logic [31:0] flash_q = 32'hFFFF_FFFF;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Reference model state
  int          m_mode = 0;   // 0 idle, 1 program pending, 2 erase pending
  int          m_cnt = 0;
  logic [31:0] m_word = 32'hFFFF_FFFF;
  int          log_q[$];
  int          pend_val = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_log_appender i_nibble_log_appender (
    .clk(clk), .rst_n(rst_n), .app_req(app_req), .app_data(app_data),
    .ready(ready), .prog_req(prog_req), .prog_word(prog_word), .prog_ack(prog_ack),
    .erase_req(erase_req), .erase_done(erase_done), .full(full), .entries(entries),
    .rd_word(flash_q), .latest(latest), .latest_valid(latest_valid)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Model update: inputs are driven at the falling edge, so they are stable here
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; log_q.delete(); flash_q = 32'hFFFF_FFFF;
    end else begin
      case (m_mode)
        0: if (app_req) begin
          if (m_cnt < 8) begin
            for (int b = 0; b < 32; b++)
              m_word[b] = (b / 4 == m_cnt) ? app_data[b % 4] : 1'b1;
            pend_val = int'(app_data);
            m_mode = 1;
          end else m_mode = 2;
        end
        1: if (prog_ack) begin
          m_cnt++;
          log_q.push_back(pend_val);
          flash_q = flash_q & m_word;
          m_mode = 0;
        end
        default: if (erase_done) begin
          m_cnt = 0; log_q.delete(); flash_q = 32'hFFFF_FFFF; m_mode = 0;
        end
      endcase
    end
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Compare every cycle, after the design has settled
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(ready == (m_mode == 0), "R4 ready", ready, m_mode == 0);
      chk(prog_req == (m_mode == 1), "R3 prog_req", prog_req, m_mode == 1);
      chk(erase_req == (m_mode == 2), "R6 erase_req", erase_req, m_mode == 2);
      chk(!(prog_req && erase_req), "R9 exclusive", {prog_req, erase_req}, 0);
      if (m_mode == 1) chk(prog_word == m_word, "R2 prog_word", prog_word, m_word);
      chk(int'(entries) == m_cnt, "R4 entries", entries, m_cnt);
      chk(full == (m_cnt == 8), "R5 full", full, m_cnt == 8);
      chk(latest_valid == (m_cnt > 0), "R7 latest_valid", latest_valid, m_cnt > 0);
      if (m_cnt > 0) chk(int'(latest) == log_q[$], "R7 latest", latest, log_q[$]);
      else           chk(latest == 4'h0, "R7 latest empty", latest, 0);
    end
  end

  task automatic append(input logic [3:0] d, input int delay, input bit poke);
    @(negedge clk); app_req = 1'b1; app_data = d;
    @(negedge clk); app_req = 1'b0;
    repeat (delay) begin
      @(negedge clk);
      if (poke) begin app_req = 1'b1; app_data = ~d; end   // R8: busy request
    end
    @(negedge clk); app_req = 1'b0; prog_ack = 1'b1;
    @(negedge clk); prog_ack = 1'b0;
  endtask

  task automatic overflow(input int delay);
    @(negedge clk); app_req = 1'b1; app_data = 4'h7;
    @(negedge clk); app_req = 1'b0;
    repeat (delay) begin
      @(negedge clk); prog_ack = 1'b1; app_req = 1'b1;   // R8: stray ack while erasing
    end
    @(negedge clk); prog_ack = 1'b0; app_req = 1'b0; erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(prog_req == 1'b0 && erase_req == 1'b0, "R1 requests", {prog_req, erase_req}, 0);
    chk(entries == 4'd0 && full == 1'b0, "R1 count", entries, 0);
    chk(latest_valid == 1'b0, "R1 latest_valid", latest_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: stray completions while idle
    prog_ack = 1'b1; @(negedge clk); prog_ack = 1'b0;
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
    chk(entries == 4'd0 && ready, "R8 stray pulses", entries, 0);
    // Fill all eight slots, varied acknowledge latency
    append(4'hA, 0, 1'b0);
    append(4'h3, 2, 1'b1);
    append(4'h0, 1, 1'b0);
    append(4'hF, 3, 1'b1);
    append(4'h5, 0, 1'b0);
    append(4'hC, 1, 1'b1);
    append(4'h9, 2, 1'b0);
    append(4'h6, 0, 1'b0);
    @(negedge clk);
    chk(full == 1'b1 && flash_q == 32'h69C5_F03A, "R5 full word", flash_q, 32'h69C5_F03A);
    // R5, R6: ninth request becomes an erase
    overflow(3);
    @(negedge clk);
    chk(entries == 4'd0 && !full, "R6 after erase", entries, 0);
    append(4'h1, 0, 1'b0);
    append(4'hE, 4, 1'b1);
    for (int k = 0; k < 6; k++) append(4'(k * 3), k % 3, 1'b0);
    overflow(0);
    append(4'h0, 1, 1'b0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule